// File: doc/BRIEF.md
# Predictive Read-Retry Voltage Controller

This sequencer sits between the host side of a flash controller and an abstract flash read port. It selects the read reference voltage for every page read. The selection starts from one stored prediction per flash block. The flash returns each read through an ECC verdict: pass or fail, plus an error count. On a failure the controller lowers the voltage by a fixed step and reads again. It repeats until the data decodes or the retry budget is spent, and a spent budget raises an uncorrectable-error pulse that carries the block and page.

Stored charge leaks over time, so the best sensing voltage of a block only moves down. A periodic tick therefore starts a background refresh pass. The pass visits the blocks in ascending order and sweeps each one downward from its current prediction. It keeps the first voltage that decodes. If no voltage decodes before the floor, it keeps the voltage that showed the fewest errors. The kept voltage becomes that block's new prediction. Host reads take priority over the pass. A paused block is swept again from its start once the host read is done.

Voltages are unsigned 8-bit DAC codes, and a runtime floor input bounds every downward step. Decoding a 2-bit cell's four levels (ascending: 11, 10, 00, 01) belongs to the flash side and is not part of this block.

Top module: `rr_vref_ctrl`

## Requirements
- R1: After reset no flash read, done or uncorrectable pulse is active, `req_ready` is high, and every block's prediction equals `DEF_V`.
- R2: The first read of a host request uses the stored prediction of the addressed block as `fl_vref`, and `fl_rd` is a single-cycle pulse.
- R3: Each retry lowers the voltage by `STEP`. The result is clamped to `vref_floor`, and a retry never issues a higher voltage than the read before it.
- R4: When a host read passes ECC, `done` pulses for one cycle and `done_vref` shows the voltage that passed.
- R5: After `MAX_RETRY` failed retries (`MAX_RETRY`+1 reads in total), `ue` pulses with `ue_blk`/`ue_page` set to the request address, and `done` does not pulse.
- R6: A `refresh_tick` starts a pass that reads page 0 of every block in ascending block order, with `fl_refresh` high. Each block's sweep starts at its stored prediction and descends by the R3 rule until a pass or until the floor has been read.
- R7: In a refresh, the first voltage that passes ECC becomes the block's new prediction.
- R8: If no refresh read of a block passes down to the floor, the voltage with the lowest `ecc_errs` becomes the prediction. On a tie the earliest, i.e. highest, voltage wins.
- R9: A host request raised during a refresh is served after the refresh read in flight completes. The refresh then resumes with the same block, restarted at its stored prediction.
- R10: One prediction serves all pages of a block: host reads of any page of a block start from the same voltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | High while the sequencer can accept a request |
| req_blk | input | BLK_W | Requested block |
| req_page | input | PAGE_W | Requested page |
| refresh_tick | input | 1 | Periodic trigger for a refresh pass |
| vref_floor | input | V_W | Lowest voltage a step may reach |
| fl_rd | output | 1 | One-cycle flash read strobe |
| fl_refresh | output | 1 | Read belongs to a refresh pass |
| fl_blk | output | BLK_W | Block of the flash read |
| fl_page | output | PAGE_W | Page of the flash read |
| fl_vref | output | V_W | Reference voltage of the flash read |
| ecc_valid | input | 1 | ECC verdict for the outstanding read |
| ecc_pass | input | 1 | Read decoded |
| ecc_errs | input | ERR_W | Reported bit-error count |
| done | output | 1 | Host read decoded (pulse) |
| done_vref | output | V_W | Voltage of the decoding read |
| ue | output | 1 | Host read uncorrectable (pulse) |
| ue_blk | output | BLK_W | Block of the failed request |
| ue_page | output | PAGE_W | Page of the failed request |

## Verification
The hardest case to reach is a host request that lands in the middle of a block's refresh sweep. Only then does the controller drop a partial sweep and restart that block. The bench's flash model makes every refresh read fail, which gives long sweeps. The bench counts refresh strobes and raises the request as the third strobe of block 0 appears. It then checks the position of the host read in the read log and the voltage of the refresh read after it. Prediction learning is observed only through the first voltage of later host reads to each page.

// File: rtl/rr_vref_ctrl.sv
module rr_vref_ctrl #(
  parameter int NBLK      = 4,
  parameter int PAGE_W    = 3,
  parameter int V_W       = 8,
  parameter int ERR_W     = 8,
  parameter int STEP      = 16,
  parameter int MAX_RETRY = 3,
  parameter int DEF_V     = 192,
  localparam int BLK_W    = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CNT_W    = $clog2(MAX_RETRY + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              refresh_tick,
  input  logic [V_W-1:0]    vref_floor,
  output logic              fl_rd,
  output logic              fl_refresh,
  output logic [BLK_W-1:0]  fl_blk,
  output logic [PAGE_W-1:0] fl_page,
  output logic [V_W-1:0]    fl_vref,
  input  logic              ecc_valid,
  input  logic              ecc_pass,
  input  logic [ERR_W-1:0]  ecc_errs,
  output logic              done,
  output logic [V_W-1:0]    done_vref,
  output logic              ue,
  output logic [BLK_W-1:0]  ue_blk,
  output logic [PAGE_W-1:0] ue_page
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t               st;
  logic              in_ref, ref_pend;
  logic [BLK_W-1:0]  ref_blk, cur_blk;
  logic [PAGE_W-1:0] cur_page;
  logic [V_W-1:0]    cur_v, best_v, next_v;
  logic [ERR_W-1:0]  best_err;
  logic [CNT_W-1:0]  retry;
  logic [V_W-1:0]    pred [NBLK];
  logic [V_W:0]      dn;
  logic              at_floor, ref_last, ref_end, better;

  assign dn       = {1'b0, cur_v} - (V_W+1)'(STEP);
  assign at_floor = cur_v <= vref_floor;
  assign next_v   = at_floor ? cur_v :
                    (dn[V_W] || dn[V_W-1:0] < vref_floor) ? vref_floor : dn[V_W-1:0];
  assign ref_last = ref_blk == BLK_W'(NBLK - 1);
  assign ref_end  = ecc_pass || at_floor;
  assign better   = ecc_errs < best_err;

  assign req_ready  = st == S_IDLE;
  assign fl_rd      = st == S_ISSUE;
  assign fl_refresh = in_ref;
  assign fl_blk     = cur_blk;
  assign fl_page    = cur_page;
  assign fl_vref    = cur_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      in_ref    <= 1'b0;
      ref_pend  <= 1'b0;
      ref_blk   <= '0;
      cur_blk   <= '0;
      cur_page  <= '0;
      cur_v     <= '0;
      best_v    <= '0;
      best_err  <= '1;
      retry     <= '0;
      done      <= 1'b0;
      done_vref <= '0;
      ue        <= 1'b0;
      ue_blk    <= '0;
      ue_page   <= '0;
      for (int i = 0; i < NBLK; i++) pred[i] <= V_W'(DEF_V);
    end else begin
      done <= 1'b0;
      ue   <= 1'b0;
      if (refresh_tick) ref_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            cur_blk  <= req_blk;
            cur_page <= req_page;
            cur_v    <= pred[req_blk];
            retry    <= '0;
            in_ref   <= 1'b0;
            st       <= S_ISSUE;
          end else if (ref_pend) begin
            cur_blk  <= ref_blk;
            cur_page <= '0;
            cur_v    <= pred[ref_blk];
            best_v   <= pred[ref_blk];
            best_err <= '1;
            in_ref   <= 1'b1;
            st       <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (ecc_valid) begin
          if (!in_ref) begin
            if (ecc_pass) begin
              done      <= 1'b1;
              done_vref <= cur_v;
              st        <= S_IDLE;
            end else if (retry == CNT_W'(MAX_RETRY)) begin
              ue      <= 1'b1;
              ue_blk  <= cur_blk;
              ue_page <= cur_page;
              st      <= S_IDLE;
            end else begin
              cur_v <= next_v;
              retry <= retry + 1'b1;
              st    <= S_ISSUE;
            end
          end else if (ref_end) begin
            pred[cur_blk] <= (ecc_pass || better) ? cur_v : best_v;
            if (ref_last) begin
              ref_blk <= '0;
              if (!refresh_tick) ref_pend <= 1'b0;
            end else begin
              ref_blk <= ref_blk + 1'b1;
            end
            st <= S_IDLE;
          end else begin
            if (better) begin
              best_v   <= cur_v;
              best_err <= ecc_errs;
            end
            if (req_valid) st <= S_IDLE;
            else begin
              cur_v <= next_v;
              st    <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [V_W-1:0] prev_v;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_v <= '0;
    else if (fl_rd) prev_v <= fl_vref;
  end

  a_r3_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && !in_ref && retry != '0) |-> fl_vref <= prev_v);
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |=> !fl_rd);
  a_r4_done_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ecc_valid && ecc_pass));
  a_r5_ue_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    ue |-> !done);
  a_r6_refresh_page0: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && fl_refresh) |-> fl_page == '0);

endmodule

// File: tb/rr_vref_ctrl_tb.sv
module rr_vref_ctrl_tb_top;
  localparam int NBLK = 4, PW = 3, STEP = 16, MAXR = 3, DEFV = 192;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, refresh_tick = 0;
  logic [1:0] req_blk = 0;
  logic [PW-1:0] req_page = 0;
  logic [7:0] vref_floor = 8'h40;
  logic ecc_valid = 0, ecc_pass = 0;
  logic [7:0] ecc_errs = 0;
  logic req_ready, fl_rd, fl_refresh, done, ue;
  logic [1:0] fl_blk, ue_blk;
  logic [PW-1:0] fl_page, ue_page;
  logic [7:0] fl_vref, done_vref;

  always #4 clk = ~clk;

  rr_vref_ctrl #(.NBLK(NBLK), .PAGE_W(PW), .STEP(STEP), .MAX_RETRY(MAXR), .DEF_V(DEFV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .req_page(req_page), .refresh_tick(refresh_tick),
    .vref_floor(vref_floor), .fl_rd(fl_rd), .fl_refresh(fl_refresh), .fl_blk(fl_blk),
    .fl_page(fl_page), .fl_vref(fl_vref), .ecc_valid(ecc_valid), .ecc_pass(ecc_pass),
    .ecc_errs(ecc_errs), .done(done), .done_vref(done_vref), .ue(ue),
    .ue_blk(ue_blk), .ue_page(ue_page));

  int n_chk = 0, n_bad = 0;
  int thr [NBLK];
  bit flat [NBLK];
  int mp [NBLK];
  int lg_v [1024], lg_b [1024], lg_p [1024];
  bit lg_r [1024];
  int n_log = 0, done_n = 0, ue_n = 0, lat = 0;
  int d_v = 0, u_b = 0, u_p = 0;
  bit p_pass;
  int p_err;

  function automatic bit f_pass(int v, int b);
    return !flat[b] && v <= thr[b];
  endfunction
  function automatic int f_err(int v, int b);
    if (flat[b]) return 5;
    if (v <= thr[b]) return 0;
    return (v - thr[b] > 255) ? 255 : v - thr[b];
  endfunction

  always @(negedge clk) begin
    ecc_valid <= 0;
    if (lat > 0) begin
      lat = lat - 1;
      if (lat == 0) begin
        ecc_valid <= 1;
        ecc_pass <= p_pass;
        ecc_errs <= 8'(p_err);
      end
    end
    if (fl_rd && n_log < 1024) begin
      lg_v[n_log] = fl_vref; lg_b[n_log] = fl_blk; lg_p[n_log] = fl_page; lg_r[n_log] = fl_refresh;
      n_log = n_log + 1;
      p_pass = f_pass(fl_vref, fl_blk);
      p_err = f_err(fl_vref, fl_blk);
      lat = 2;
    end
    if (done) begin done_n = done_n + 1; d_v = done_vref; end
    if (ue) begin ue_n = ue_n + 1; u_b = ue_blk; u_p = ue_page; end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic user_read(int b, int p);
    int ends;
    ends = done_n + ue_n;
    @(negedge clk);
    req_valid = 1; req_blk = 2'(b); req_page = PW'(p);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (done_n + ue_n == ends) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int step_dn(int v);
    if (v <= vref_floor) return v;
    return (v - STEP < vref_floor) ? int'(vref_floor) : v - STEP;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad = n_bad + 1;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int st0, d0, u0, e_n, u, ok;
    int exp_v [64];
    for (int b = 0; b < NBLK; b++) begin thr[b] = 255; flat[b] = 0; mp[b] = DEFV; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!fl_rd && !done && !ue && req_ready, "R1 idle after reset", int'(fl_rd), 0);

    // R1 R2 R3 R4 R10: pass on retry k, all blocks
    for (int b = 0; b < NBLK; b++)
      for (int k = 0; k <= MAXR; k++) begin
        thr[b] = DEFV - k * STEP;
        st0 = n_log;
        d0 = done_n;
        user_read(b, (b + k) % 8);
        chk(n_log - st0 == k + 1, "R3 read count", n_log - st0, k + 1);
        ok = 1;
        for (int i = 0; i <= k; i++)
          if (lg_v[st0+i] != DEFV - i * STEP || lg_b[st0+i] != b ||
              lg_p[st0+i] != (b + k) % 8 || lg_r[st0+i]) ok = 0;
        chk(ok == 1, "R2 R3 voltage sequence", lg_v[st0 + k], DEFV - k * STEP);
        chk(done_n == d0 + 1 && d_v == DEFV - k * STEP, "R4 done voltage", d_v, DEFV - k * STEP);
      end

    // R5 uncorrectable
    thr[2] = 0;
    st0 = n_log; d0 = done_n; u0 = ue_n;
    user_read(2, 6);
    chk(ue_n == u0 + 1 && done_n == d0, "R5 ue pulse only", ue_n - u0, 1);
    chk(u_b == 2 && u_p == 6, "R5 ue address", u_b * 8 + u_p, 22);
    chk(n_log - st0 == MAXR + 1, "R5 read count", n_log - st0, MAXR + 1);

    // R3 floor clamp
    vref_floor = 8'hAC; thr[1] = 0;
    st0 = n_log;
    user_read(1, 3);
    chk(lg_v[st0] == 8'hC0 && lg_v[st0+1] == 8'hB0 && lg_v[st0+2] == 8'hAC && lg_v[st0+3] == 8'hAC,
        "R3 floor clamp", lg_v[st0+2], 8'hAC);

    // R6 R7 R8 refresh pass
    vref_floor = 8'h40;
    thr[0] = 8'hA5; thr[1] = 8'hC0; thr[2] = 0; thr[3] = 0; flat[3] = 1;
    e_n = 0;
    for (int b = 0; b < NBLK; b++) begin
      int v, best, be;
      v = mp[b]; best = v; be = 256;
      forever begin
        exp_v[e_n] = b * 256 + v; e_n = e_n + 1;
        if (f_pass(v, b)) begin mp[b] = v; break; end
        if (f_err(v, b) < be) begin be = f_err(v, b); best = v; end
        if (v <= vref_floor) begin mp[b] = best; break; end
        v = step_dn(v);
      end
    end
    st0 = n_log;
    @(negedge clk); refresh_tick = 1; @(negedge clk); refresh_tick = 0;
    repeat (400) @(negedge clk);
    chk(n_log - st0 == e_n, "R6 refresh read count", n_log - st0, e_n);
    ok = 1;
    for (int i = 0; i < e_n; i++)
      if (lg_b[st0+i] * 256 + lg_v[st0+i] != exp_v[i] || !lg_r[st0+i] || lg_p[st0+i] != 0) ok = 0;
    chk(ok == 1, "R6 refresh order and sweep", ok, 1);
    for (int b = 0; b < NBLK; b++) begin thr[b] = 255; flat[b] = 0; end
    for (int b = 0; b < NBLK; b++)
      for (int p = 0; p < 8; p++) begin
        st0 = n_log;
        user_read(b, p);
        chk(lg_v[st0] == mp[b], b == 2 ? "R8 lowest-error prediction" :
            b == 3 ? "R8 tie keeps earliest" : b == 0 ? "R7 first pass stored" : "R10 shared prediction",
            lg_v[st0], mp[b]);
      end

    // R9 host read preempts refresh
    for (int b = 0; b < NBLK; b++) thr[b] = 0;
    st0 = n_log;
    @(negedge clk); refresh_tick = 1; @(negedge clk); refresh_tick = 0;
    while (n_log - st0 < 3) @(negedge clk);
    thr[3] = 255;
    user_read(3, 5);
    repeat (600) @(negedge clk);
    u = -1;
    for (int i = st0; i < n_log; i++) if (!lg_r[i] && u < 0) u = i;
    chk(u - st0 == 3 && lg_r[u-1] && lg_b[u-1] == 0, "R9 preempt after read in flight", u - st0, 3);
    chk(lg_v[u] == mp[3] && lg_b[u] == 3 && lg_p[u] == 5, "R9 host read voltage", lg_v[u], mp[3]);
    chk(lg_r[u+1] && lg_b[u+1] == 0 && lg_v[u+1] == mp[0], "R9 block restarted", lg_v[u+1], mp[0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule